// File: doc/BRIEF.md
# Supported Correction Strength Quantizer

This unit takes a requested error-correction strength and snaps it onto an ordered table of strengths that the correction engine supports. The table is a parameter: a packed vector of strictly ascending entries, entry 0 in the least significant slot. A request that falls between two entries is rounded down to the lower one. A request below the smallest entry is clamped up to that smallest entry. A request above the largest entry is clamped to the largest entry.

Along with the adjusted strength, the unit returns the table position of that entry, which is used as the strength code of a configuration word. It also returns a flag that is high only when the request matched an entry exactly. A request without an exact match is therefore not a valid configuration code. All entries are compared in parallel, and the result is delivered through a two-stage pipeline. A new request may be issued every cycle.

Top module: `strq_top`

## Requirements
- R1: Every adjusted strength output is an entry of the parameter table, and the reported index is that entry's position, where position 0 is the least significant `STR_W`-bit slot of `TABLE`.
- R2: A request equal to a table entry returns that entry unchanged, its position as index, and `match_o` = 1.
- R3: A request strictly between two adjacent entries returns the lower entry and its position, with `match_o` = 0.
- R4: A request below the first entry returns the first entry and index 0, with `match_o` = 0.
- R5: A request above the last entry returns the last entry and index `DEPTH-1`, with `match_o` = 0.
- R6: `match_o` is high only when the request equals some entry. At most one entry matches.
- R7: `ready_o` pulses for one cycle exactly two clock edges after each cycle in which `req_valid_i` is sampled high. Back-to-back requests give back-to-back results in order.
- R8: After reset, `ready_o` is low and the result outputs are zero.
- R9: The result outputs hold their last value while no new result is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_str_i | input | STR_W | Requested strength |
| ready_o | output | 1 | Result strobe, two cycles after the request |
| str_o | output | STR_W | Adjusted strength |
| idx_o | output | IDX_W | Table position of the adjusted strength |
| match_o | output | 1 | The request equalled a table entry |

## Verification
The bench builds two instances. The first uses the default 23-entry table with 8-bit strengths. The second uses a 5-entry table running from 4 to 12 in steps of 2. Both are swept over every 8-bit request value back to back. This covers every exact hit, every gap between entries, the clamp below the floor (including zero), and the clamp above the ceiling up to 255. It also covers the uneven steps of 2, 4 and 8 in the larger table. A gap in the request stream then shows that `ready_o` falls and that the results are held.

// File: rtl/strq_pkg.sv
package strq_pkg;
  localparam int unsigned DEF_W = 8;
  localparam int unsigned DEF_N = 23;

  // default: 4..24 step 2, 28..60 step 4, then 68, 72, 80
  function automatic logic [DEF_N*DEF_W-1:0] def_table();
    logic [DEF_N*DEF_W-1:0] t;
    int unsigned v;
    t = '0;
    for (int unsigned i = 0; i < DEF_N; i++) begin
      if (i < 11)       v = 4 + 2*i;
      else if (i < 20)  v = 28 + 4*(i-11);
      else if (i == 20) v = 68;
      else if (i == 21) v = 72;
      else              v = 80;
      t[i*DEF_W +: DEF_W] = DEF_W'(v);
    end
    return t;
  endfunction
endpackage

// File: rtl/strq_cmp.sv
module strq_cmp #(
  parameter int unsigned STR_W = 8,
  parameter int unsigned DEPTH = 23
) (
  input  logic [STR_W-1:0]       req_i,
  input  logic [DEPTH*STR_W-1:0] table_i,
  output logic [DEPTH-1:0]       ge_o,
  output logic [DEPTH-1:0]       eq_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign ge_o[g] = req_i >= table_i[g*STR_W +: STR_W];
    assign eq_o[g] = req_i == table_i[g*STR_W +: STR_W];
  end
endmodule

// File: rtl/strq_sel.sv
module strq_sel #(
  parameter int unsigned DEPTH = 23,
  parameter int unsigned IDX_W = 5
) (
  input  logic [DEPTH-1:0] ge_i,
  input  logic [DEPTH-1:0] eq_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             hit_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  logic [CNT_W-1:0] cnt;

  // ascending table makes ge a thermometer; its weight points past the pick
  always_comb begin
    cnt = '0;
    for (int unsigned i = 0; i < DEPTH; i++) cnt = cnt + CNT_W'(ge_i[i]);
  end

  assign idx_o = (cnt == '0) ? '0 : IDX_W'(cnt - 1'b1);
  assign hit_o = |eq_i;
endmodule

// File: rtl/strq_top.sv
module strq_top
  import strq_pkg::*;
#(
  parameter int unsigned              STR_W = DEF_W,
  parameter int unsigned              DEPTH = DEF_N,
  parameter logic [DEPTH*STR_W-1:0]   TABLE = def_table(),
  localparam int unsigned             IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [STR_W-1:0] req_str_i,
  output logic             ready_o,
  output logic [STR_W-1:0] str_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             match_o
);
  logic [DEPTH-1:0] ge_d, eq_d, ge_q, eq_q;
  logic             v_q;
  logic [IDX_W-1:0] idx_d;
  logic             hit_d;

  strq_cmp #(.STR_W(STR_W), .DEPTH(DEPTH)) cmp_i (
    .req_i(req_str_i), .table_i(TABLE), .ge_o(ge_d), .eq_o(eq_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q  <= 1'b0;
      ge_q <= '0;
      eq_q <= '0;
    end else begin
      v_q <= req_valid_i;
      if (req_valid_i) begin
        ge_q <= ge_d;
        eq_q <= eq_d;
      end
    end
  end

  strq_sel #(.DEPTH(DEPTH), .IDX_W(IDX_W)) sel_i (
    .ge_i(ge_q), .eq_i(eq_q), .idx_o(idx_d), .hit_o(hit_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o <= 1'b0;
      str_o   <= '0;
      idx_o   <= '0;
      match_o <= 1'b0;
    end else begin
      ready_o <= v_q;
      if (v_q) begin
        str_o   <= TABLE[idx_d*STR_W +: STR_W];
        idx_o   <= idx_d;
        match_o <= hit_d;
      end
    end
  end

  AST_THERMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q |-> ((ge_q + 1'b1) & ge_q) == '0);  // R1
  AST_ONE_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q |-> $onehot0(eq_q));  // R6
  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> ##2 ready_o);  // R7
  AST_EXACT_SAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && match_o) |-> str_o == $past(req_str_i, 2));  // R2
  AST_UP_ONLY_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && str_o > $past(req_str_i, 2)) |-> idx_o == '0);  // R4
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> $stable(str_o) && $stable(idx_o) && $stable(match_o));  // R9
endmodule

// File: tb/strq_top_tb_top.sv
module strq_top_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned W  = 8;
  localparam int unsigned NB = 23;
  localparam int unsigned NS = 5;
  localparam logic [NS*W-1:0] SMALL_TAB = {8'd12, 8'd10, 8'd8, 8'd6, 8'd4};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [W-1:0] req = '0;
  logic rdy_b, rdy_s, mt_b, mt_s;
  logic [W-1:0] str_b, str_s;
  logic [4:0] idx_b;
  logic [2:0] idx_s;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strq_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_str_i(req),
    .ready_o(rdy_b), .str_o(str_b), .idx_o(idx_b), .match_o(mt_b)
  );

  strq_top #(.STR_W(W), .DEPTH(NS), .TABLE(SMALL_TAB)) dut_s (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_str_i(req),
    .ready_o(rdy_s), .str_o(str_s), .idx_o(idx_s), .match_o(mt_s)
  );

  function automatic int ent(bit big, int i);
    if (!big) return 4 + 2*i;
    if (i < 11) return 4 + 2*i;
    if (i < 20) return 28 + 4*(i-11);
    if (i == 20) return 68;
    if (i == 21) return 72;
    return 80;
  endfunction

  function automatic int exp_idx(bit big, int r);
    int n = big ? NB : NS;
    int c = 0;
    for (int i = 0; i < n; i++) if (ent(big, i) <= r) c++;
    return (c == 0) ? 0 : c - 1;
  endfunction

  function automatic bit exp_hit(bit big, int r);
    int n = big ? NB : NS;
    for (int i = 0; i < n; i++) if (ent(big, i) == r) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string rtag(bit big, int r);
    int n = big ? NB : NS;
    if (exp_hit(big, r)) return "R2";
    if (r < ent(big, 0)) return "R4";
    if (r > ent(big, n-1)) return "R5";
    return "R3";
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_res(bit big, int r);
    int ei = exp_idx(big, r);
    string t = rtag(big, r);
    if (big) begin
      chk({t, " R7 rdy big"}, int'(rdy_b), 1);
      chk({t, " R1 str big"}, int'(str_b), ent(1, ei));
      chk({t, " R1 idx big"}, int'(idx_b), ei);
      chk({t, " R6 match big"}, int'(mt_b), int'(exp_hit(1, r)));
    end else begin
      chk({t, " R7 rdy small"}, int'(rdy_s), 1);
      chk({t, " R1 str small"}, int'(str_s), ent(0, ei));
      chk({t, " R1 idx small"}, int'(idx_s), ei);
      chk({t, " R6 match small"}, int'(mt_s), int'(exp_hit(0, r)));
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    chk("R8 rdy big", int'(rdy_b), 0);
    chk("R8 str big", int'(str_b), 0);
    chk("R8 idx big", int'(idx_b), 0);
    chk("R8 rdy small", int'(rdy_s), 0);
    chk("R8 match small", int'(mt_s), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // back-to-back sweep of every request value
    for (int r = 0; r < 258; r++) begin
      if (r >= 2) begin
        chk_res(1'b1, r - 2);
        chk_res(1'b0, r - 2);
      end
      vld = (r < 256);
      req = W'(r);
      @(negedge clk);
    end
    // idle: ready falls, results hold from request 255
    vld = 1'b0;
    req = 8'd7;
    repeat (3) begin
      chk("R7 rdy idle big", int'(rdy_b), 0);
      chk("R7 rdy idle small", int'(rdy_s), 0);
      chk("R9 hold str big", int'(str_b), 80);
      chk("R9 hold idx big", int'(idx_b), 22);
      chk("R9 hold str small", int'(str_s), 12);
      chk("R9 hold idx small", int'(idx_s), 4);
      @(negedge clk);
    end
    // isolated request: single pulse at exactly two edges
    vld = 1'b1;
    req = 8'd27;
    @(negedge clk);
    vld = 1'b0;
    chk("R7 early big", int'(rdy_b), 0);
    @(negedge clk);
    chk_res(1'b1, 27);
    chk_res(1'b0, 27);
    @(negedge clk);
    chk("R7 single pulse big", int'(rdy_b), 0);
    chk("R9 hold str big", int'(str_b), 24);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule